// File: doc/BRIEF.md
# Converter Trigger and Channel Scan Sequencer

This block is the digital control for a four-input successive-approximation converter. It decides when a conversion sequence begins, which input is converted next, and whether the sequence repeats. A conversion can be started by a timer overflow pulse, by an edge of an external pin with selectable polarity, or at once by a register write. Three sequencing modes are available: one pass over the enabled inputs, continuous conversion of a single input, and continuous scanning over all enabled inputs.

The analog core sits outside the block. The sequencer presents a channel number with a one-cycle start strobe. The core answers some cycles later with an 8-bit result and a one-cycle done pulse. Starts are paced by a prescaled conversion tick derived from the system clock. Each result lands in its own per-channel data register. A sticky completion flag, gated by an interrupt enable, drives the interrupt line. Software reaches every setting through a simple write port and a combinational read port.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset every register reads zero, no start strobe is issued and `irq` is low.
- R2: While the enable bit (bit 0 at address 0) is clear, timer and pin triggers start nothing.
- R3: With start mode 0 (bits 2:1 at address 0), a high `timerOvf` in an idle cycle starts a sequence.
- R4: With start mode 1, a `trigPin` edge starts a sequence. Bit 3 at address 0 selects the edge: 1 means rising and 0 means falling. An edge of the other direction is ignored.
- R5: With start mode 2, a write to address 0 that sets the enable bit starts a sequence at once.
- R6: A prescale counter wraps to zero and produces a tick in every cycle where its count is at least the divider (bits 7:4 at address 1). The start strobe appears only in a tick cycle while enabled, and its first possible cycle is the one after the trigger.
- R7: Conversion mode 0 (bits 1:0 at address 1) converts each enabled input once, in ascending index order, and then goes idle. The flag is set when the last input is stored. Disabled inputs are never converted.
- R8: Conversion mode 1 repeatedly converts the lowest enabled input and sets the flag after each result.
- R9: Conversion mode 2 visits the enabled inputs in ascending order and wraps from the highest back to the lowest without stopping. The flag is set at the end of each pass.
- R10: Each result presented with `convDone` is stored in the data register at address 4 plus the channel index.
- R11: The completion flag (bit 5 at address 0) stays set until a write to address 0 carries bit 5 low. A set in the same cycle as a clear wins.
- R12: `irq` is high exactly when the flag and the interrupt enable (bit 4 at address 0) are both set.
- R13: Triggers that arrive while a sequence is pending or converting are ignored. A trigger with an all-zero input mask (bits 3:0 at address 2) starts nothing.
- R14: Clearing the enable bit lets a running conversion finish and store its result. No further start is issued after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from `regAddr` |
| timerOvf | input | 1 | Timer overflow pulse (trigger source) |
| trigPin | input | 1 | External trigger pin |
| convStart | output | 1 | One-cycle start strobe to the converter core |
| convChan | output | 2 | Channel to convert, valid with `convStart` |
| convDone | input | 1 | One-cycle completion pulse from the core |
| convResult | input | 8 | Conversion result, valid with `convDone` |
| irq | output | 1 | Completion interrupt |

## Verification
Each sequencing mode is run against a different input mask, so that gaps in the mask show up. An ascending single pass over inputs 0, 1 and 3 shows whether a disabled input is skipped. A fixed run on mask 0110 shows whether the lowest input is chosen. A scan on mask 1001 shows whether the sequencer wraps across the gap. Timer, falling-edge and immediate starts are each used once. A second timer pulse fired in the middle of a pass, and a pin edge of the wrong direction, show whether triggers are gated correctly. Prescale dividers of 2 and 0 show whether starts follow the tick. A behavioural model predicts every start strobe, channel and interrupt level in every cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    START_TIMER = 2'd0,
    START_EDGE  = 2'd1,
    START_NOW   = 2'd2,
    START_NONE  = 2'd3
  } startMode_e;

  typedef enum logic [1:0] {
    CONV_ONCE = 2'd0,
    CONV_HOLD = 2'd1,
    CONV_SCAN = 2'd2,
    CONV_RSVD = 2'd3
  } convMode_e;

  typedef struct packed {
    logic store;
    logic setFlag;
  } seqStrobes_t;

endpackage

// File: rtl/adc_seq_prescale.sv
module adc_seq_prescale #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);

  logic [DIV_W-1:0] cntQ;

  assign tick = (cntQ >= divider);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (tick) begin
      cntQ <= '0;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4,
  parameter int ADDR_W = 3,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] convResult,
  input  logic [CH_W-1:0]   storeChan,
  input  seqStrobes_t       strobes,
  output logic              enable,
  output startMode_e        startMode,
  output logic              edgeRising,
  output convMode_e         convMode,
  output logic [NUM_CH-1:0] chanMask,
  output logic [DIV_W-1:0]  divider,
  output logic              immStart,
  output logic              flag,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_MODE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(2);
  localparam int DATA_BASE = 4;
  localparam int BIT_EN    = 0;
  localparam int BIT_SM    = 1;
  localparam int BIT_EDGE  = 3;
  localparam int BIT_IRQEN = 4;
  localparam int BIT_FLAG  = 5;
  localparam int BIT_CM    = 0;
  localparam int BIT_DIV   = 4;

  logic              enQ;
  startMode_e        startModeQ;
  logic              edgeRisingQ;
  logic              irqEnQ;
  logic              flagQ;
  convMode_e         convModeQ;
  logic [DIV_W-1:0]  divQ;
  logic [NUM_CH-1:0] maskQ;
  logic [DATA_W-1:0] dataQ [NUM_CH];

  logic ctrlWr, modeWr, maskWr;
  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);
  assign modeWr = regWrEn && (regAddr == ADDR_MODE);
  assign maskWr = regWrEn && (regAddr == ADDR_MASK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ         <= 1'b0;
      startModeQ  <= START_TIMER;
      edgeRisingQ <= 1'b0;
      irqEnQ      <= 1'b0;
    end else if (ctrlWr) begin
      enQ         <= regWrData[BIT_EN];
      startModeQ  <= startMode_e'(regWrData[BIT_SM +: 2]);
      edgeRisingQ <= regWrData[BIT_EDGE];
      irqEnQ      <= regWrData[BIT_IRQEN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strobes.setFlag) begin
      flagQ <= 1'b1;
    end else if (ctrlWr && !regWrData[BIT_FLAG]) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      convModeQ <= CONV_ONCE;
      divQ      <= '0;
    end else if (modeWr) begin
      convModeQ <= convMode_e'(regWrData[BIT_CM +: 2]);
      divQ      <= regWrData[BIT_DIV +: DIV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (maskWr) begin
      maskQ <= regWrData[NUM_CH-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gData
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataQ[g] <= '0;
      end else if (strobes.store && (storeChan == CH_W'(g))) begin
        dataQ[g] <= convResult;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL) begin
      regRdData[BIT_EN]        = enQ;
      regRdData[BIT_SM +: 2]   = startModeQ;
      regRdData[BIT_EDGE]      = edgeRisingQ;
      regRdData[BIT_IRQEN]     = irqEnQ;
      regRdData[BIT_FLAG]      = flagQ;
    end else if (regAddr == ADDR_MODE) begin
      regRdData[BIT_CM +: 2]   = convModeQ;
      regRdData[BIT_DIV +: DIV_W] = divQ;
    end else if (regAddr == ADDR_MASK) begin
      regRdData[NUM_CH-1:0]    = maskQ;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (regAddr == ADDR_W'(DATA_BASE + i)) begin
          regRdData = dataQ[i];
        end
      end
    end
  end

  assign immStart   = ctrlWr && regWrData[BIT_EN] &&
                      (regWrData[BIT_SM +: 2] == START_NOW);
  assign enable     = enQ;
  assign startMode  = startModeQ;
  assign edgeRising = edgeRisingQ;
  assign convMode   = convModeQ;
  assign chanMask   = maskQ;
  assign divider    = divQ;
  assign flag       = flagQ;
  assign irq        = flagQ && irqEnQ;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  startMode_e        startMode,
  input  logic              edgeRising,
  input  convMode_e         convMode,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic              tick,
  input  logic              immStart,
  input  logic              timerOvf,
  input  logic              trigPin,
  input  logic              convDone,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  output seqStrobes_t       strobes
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CONV} seqState_e;

  seqState_e       stateQ, stateD;
  logic [CH_W-1:0] chanQ, chanD;
  logic            pinPrevQ;

  // Returns {found, index} of the lowest set mask bit at or above lo.
  function automatic logic [CH_W:0] pickFrom(input logic [NUM_CH-1:0] m, input int lo);
    logic [CH_W:0] res;
    res = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i] && (i >= lo)) begin
        res = {1'b1, CH_W'(i)};
      end
    end
    return res;
  endfunction

  logic [CH_W:0] firstPick, abovePick;
  logic          edgeHit, startReq;

  assign firstPick = pickFrom(chanMask, 0);
  assign abovePick = pickFrom(chanMask, int'(chanQ) + 1);
  assign edgeHit   = edgeRising ? (trigPin && !pinPrevQ) : (!trigPin && pinPrevQ);
  assign startReq  = immStart ||
                     (enable && (((startMode == START_TIMER) && timerOvf) ||
                                 ((startMode == START_EDGE) && edgeHit)));

  always_comb begin
    stateD    = stateQ;
    chanD     = chanQ;
    strobes   = '0;
    convStart = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (startReq && (|chanMask)) begin
          stateD = S_WAIT;
          chanD  = firstPick[CH_W-1:0];
        end
      end
      S_WAIT: begin
        if (!enable) begin
          stateD = S_IDLE;
        end else if (tick) begin
          convStart = 1'b1;
          stateD    = S_CONV;
        end
      end
      S_CONV: begin
        if (convDone) begin
          strobes.store = 1'b1;
          if (convMode == CONV_HOLD) begin
            strobes.setFlag = 1'b1;
            stateD = enable ? S_WAIT : S_IDLE;
          end else if (abovePick[CH_W]) begin
            chanD  = abovePick[CH_W-1:0];
            stateD = enable ? S_WAIT : S_IDLE;
          end else begin
            strobes.setFlag = 1'b1;
            if ((convMode == CONV_SCAN) && enable && firstPick[CH_W]) begin
              chanD  = firstPick[CH_W-1:0];
              stateD = S_WAIT;
            end else begin
              stateD = S_IDLE;
            end
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      chanQ    <= '0;
      pinPrevQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      chanQ    <= chanD;
      pinPrevQ <= trigPin;
    end
  end

  assign convChan = chanQ;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 4,
  parameter int ADDR_W = 3,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              timerOvf,
  input  logic              trigPin,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  output logic              irq
);

  seqStrobes_t       strobesW;
  logic              enableW, edgeRisingW, immStartW, flagW, tickW;
  startMode_e        startModeW;
  convMode_e         convModeW;
  logic [NUM_CH-1:0] maskW;
  logic [DIV_W-1:0]  dividerW;

  adc_seq_regs #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .convResult (convResult),
    .storeChan  (convChan),
    .strobes    (strobesW),
    .enable     (enableW),
    .startMode  (startModeW),
    .edgeRising (edgeRisingW),
    .convMode   (convModeW),
    .chanMask   (maskW),
    .divider    (dividerW),
    .immStart   (immStartW),
    .flag       (flagW),
    .irq        (irq)
  );

  adc_seq_prescale #(.DIV_W(DIV_W)) prescale_i (
    .clk     (clk),
    .rstN    (rstN),
    .divider (dividerW),
    .tick    (tickW)
  );

  adc_seq_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enableW),
    .startMode  (startModeW),
    .edgeRising (edgeRisingW),
    .convMode   (convModeW),
    .chanMask   (maskW),
    .tick       (tickW),
    .immStart   (immStartW),
    .timerOvf   (timerOvf),
    .trigPin    (trigPin),
    .convDone   (convDone),
    .convStart  (convStart),
    .convChan   (convChan),
    .strobes    (strobesW)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              convStart,
  input logic              convDone,
  input logic              irq,
  input logic              tick,
  input logic              enable,
  input logic              store,
  input logic              setFlag,
  input logic              flag,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData
);

  assert_start_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> tick);

  assert_start_enabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> enable);

  assert_single_outstanding_R13: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_store_on_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    store |-> convDone);

  assert_flag_sticks_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !(regWrEn && (regAddr == '0) && !regWrData[5])) |=> flag);

  assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rstN)
    setFlag |=> flag);

  assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .convStart (convStart),
  .convDone  (convDone),
  .irq       (irq),
  .tick      (tickW),
  .enable    (enableW),
  .store     (strobesW.store),
  .setFlag   (strobesW.setFlag),
  .flag      (flagW),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb_top;

  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       timerOvf = 1'b0;
  logic       trigPin = 1'b0;
  logic       convStart;
  logic [1:0] convChan;
  logic       convDone = 1'b0;
  logic [7:0] convResult = '0;
  logic       irq;

  always #5 clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .timerOvf(timerOvf),
    .trigPin(trigPin), .convStart(convStart), .convChan(convChan),
    .convDone(convDone), .convResult(convResult), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int startCount = 0;

  // Behavioural reference state
  int mSt = 0;          // 0 idle, 1 waiting for tick, 2 converting
  int mCh = 0;
  int mCnt = 0;
  int mEn = 0, mSm = 0, mRise = 0, mIrqEn = 0, mFlag = 0;
  int mCm = 0, mDiv = 0, mMask = 0;
  int mData [4] = '{0, 0, 0, 0};
  int mPinPrev = 0;
  int doneCnt = 0, seqNo = 0, resVal = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(int m, int from);
    for (int i = from; i < 4; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic modelStep();
    int cd, tick, expStart, nst, nch, store, setF, trig, n, imm;
    cd = 0;
    if (doneCnt > 0) begin
      doneCnt--;
      if (doneCnt == 0) cd = 1;
    end
    convDone   = cd[0];
    convResult = cd ? 8'(resVal) : 8'h00;
    tick = (mCnt >= mDiv);
    expStart = (mSt == 1) && tick && mEn;
    check("R6 start strobe", int'(convStart), expStart);
    if (expStart) check("R7 channel order", int'(convChan), mCh);
    check("R12 irq level", int'(irq), mFlag && mIrqEn);
    if (convStart) begin
      startCount++;
      doneCnt = LAT;
      seqNo++;
      resVal = (int'(convChan) * 64 + seqNo) & 255;
    end
    imm = regWrEn && regAddr == 0 && regWrData[0] && regWrData[2:1] == 2;
    nst = mSt; nch = mCh; store = 0; setF = 0;
    case (mSt)
      0: begin
        trig = imm;
        if (mEn && mSm == 0 && timerOvf) trig = 1;
        if (mEn && mSm == 1 && (mRise ? (trigPin && !mPinPrev) : (!trigPin && mPinPrev))) trig = 1;
        if (trig && mMask != 0) begin nst = 1; nch = lowest(mMask, 0); end
      end
      1: begin
        if (!mEn) nst = 0;
        else if (tick) nst = 2;
      end
      default: begin
        if (cd) begin
          store = 1;
          if (mCm == 1) begin
            setF = 1; nst = mEn ? 1 : 0;
          end else begin
            n = lowest(mMask, mCh + 1);
            if (n >= 0) begin
              nch = n; nst = mEn ? 1 : 0;
            end else begin
              setF = 1;
              if (mCm == 2 && mEn && mMask != 0) begin nst = 1; nch = lowest(mMask, 0); end
              else nst = 0;
            end
          end
        end
      end
    endcase
    mCnt = tick ? 0 : mCnt + 1;
    if (store) mData[mCh] = int'(convResult);
    if (regWrEn) begin
      case (regAddr)
        3'd0: begin
          mEn = regWrData[0]; mSm = regWrData[2:1]; mRise = regWrData[3];
          mIrqEn = regWrData[4];
          if (!regWrData[5]) mFlag = 0;
        end
        3'd1: begin mCm = regWrData[1:0]; mDiv = regWrData[7:4]; end
        3'd2: mMask = regWrData[3:0];
        default: ;
      endcase
    end
    if (setF) mFlag = 1;
    mPinPrev = trigPin;
    mSt = nst; mCh = nch;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rstN) modelStep();
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = 8'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(string tag, int a, int exp);
    @(negedge clk);
    regAddr = 3'(a);
    #2;
    check(tag, int'(regRdData), exp);
  endtask

  task automatic pulseTimer();
    @(negedge clk);
    timerOvf = 1'b1;
    @(negedge clk);
    timerOvf = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    rd("R1 ctrl reset", 0, 0);
    rd("R1 mode reset", 1, 0);
    rd("R1 mask reset", 2, 0);
    for (int i = 4; i < 8; i++) rd("R1 data reset", i, 0);
    check("R1 irq reset", int'(irq), 0);

    // R2: disabled timer trigger does nothing
    wr(2, 8'h0B);
    wr(1, 8'h20);
    wr(0, 8'h20);
    s0 = startCount;
    pulseTimer();
    idle(20);
    check("R2 no start when disabled", startCount - s0, 0);
    rd("R2 data untouched", 4, 0);

    // R3/R7/R13: timer start, single pass over 0,1,3; second pulse ignored
    wr(0, 8'h21);
    pulseTimer();
    idle(3);
    pulseTimer();
    idle(60);
    check("R7 single pass start count", startCount - s0, 3);
    rd("R3 flag after timer pass", 0, 8'h21);
    rd("R10 data ch0", 4, 8'h01);
    rd("R10 data ch1", 5, 8'h42);
    rd("R7 disabled ch2 untouched", 6, 0);
    rd("R10 data ch3", 7, 8'hC3);
    check("R12 irq masked", int'(irq), 0);
    wr(0, 8'h31);
    idle(1);
    check("R12 irq enabled", int'(irq), 1);
    wr(0, 8'h11);
    rd("R11 flag cleared", 0, 8'h11);
    check("R11 irq after clear", int'(irq), 0);

    // R4: falling edge mode, rising edge ignored
    wr(0, 8'h13);
    s0 = startCount;
    @(negedge clk); trigPin = 1'b1;
    idle(15);
    check("R4 rising ignored in falling mode", startCount - s0, 0);
    @(negedge clk); trigPin = 1'b0;
    idle(60);
    check("R4 falling edge pass", startCount - s0, 3);
    rd("R4 data ch0 after edge pass", 4, 8'h04);
    check("R12 irq after pass", int'(irq), 1);

    // R5/R8/R14: immediate start, fixed mode on lowest of 0110, then disable
    wr(0, 8'h11);
    wr(2, 8'h06);
    wr(1, 8'h01);
    s0 = startCount;
    wr(0, 8'h35);
    idle(30);
    check("R5 immediate start happened", int'(startCount > s0), 1);
    rd("R8 ch2 never converted", 6, 0);
    check("R8 flag set in fixed mode", mFlag, 1);
    wr(0, 8'h34);
    idle(10);
    s0 = startCount;
    idle(20);
    check("R14 no start after disable", startCount - s0, 0);
    rd("R14 last result stored", 5, mData[1]);

    // R9: scan over 1001 with wrap, divider 0
    wr(2, 8'h09);
    wr(1, 8'h02);
    s0 = startCount;
    wr(0, 8'h15);
    idle(50);
    check("R9 scan keeps running", int'(startCount - s0 > 4), 1);
    wr(0, 8'h14);
    idle(15);
    rd("R9 ch3 result", 7, mData[3]);
    rd("R9 ch0 result", 4, mData[0]);
    rd("R9 ch1 untouched by scan", 5, mData[1]);

    // R13: zero mask starts nothing
    wr(2, 8'h00);
    s0 = startCount;
    wr(0, 8'h15);
    idle(15);
    check("R13 zero mask no start", startCount - s0, 0);
    wr(0, 8'h34);
    idle(5);

    finished = 1;
    summary();
  end

endmodule